// File: doc/BRIEF.md
# Flash Write-Protect Guard with Status Indicators

This block sits between a board-level write-protect switch and the write-protect line of the attached flash devices. It filters the raw switch, tells the host-facing logic whether the media must be treated as read-only, and refuses configuration-area writes while protection is requested. The hardware write-protect line to the flash is not pulled low while a data transfer is in flight or while the controller core still has internal work queued. It drops only after that work has drained, so a flash program operation is never cut off partway. Releasing the switch lifts the line again at once, because nothing can be lost in that direction.

The same block drives two open-drain style indicators, expressed as sink enables. When an enable is 1 the pad sinks current (line low). When it is 0 the pad is released to high-Z. One indicator shows data-transfer activity and the other shows that the device is up and initialized. The controller core supplies single-cycle transfer start and finish strobes, a level for pending internal operations, and an initialization-complete level.

Top module: `wp_guard`

## Requirements
- R1: A switch level that differs from the filtered level and then holds steady for DEB_CYCLES consecutive cycles is adopted. `prot_status` is 1 exactly while the adopted level is low. The change reaches `prot_status` after no fewer than DEB_CYCLES and no more than DEB_CYCLES+3 clock edges from the pin change.
- R2: A switch excursion shorter than DEB_CYCLES cycles leaves `prot_status` and `flash_wp_n` unchanged.
- R3: When `prot_status` is 1 in a cycle with no transfer active, no start strobe and `ops_pending` low, `flash_wp_n` is 0 from the next cycle on.
- R4: While a transfer is active or `ops_pending` is 1, a `flash_wp_n` that is 1 stays 1. It falls in the cycle after the last of these conditions clears.
- R5: A `xfer_start` strobe in the same cycle in which protection would otherwise be applied defers the application.
- R6: In any cycle in which `prot_status` is 0, `flash_wp_n` is 1 in the following cycle.
- R7: When `cfg_wr_req` is 1, exactly one of `cfg_wr_grant` or `cfg_wr_reject` is 1 in the same cycle. Reject is chosen whenever `prot_status` is 1, including while application is still deferred. Both are 0 without a request.
- R8: `act_sink_en` becomes 1 in the cycle after `xfer_start` and 0 in the cycle after `xfer_done`. If both strobes arrive in the same cycle, start wins and the indicator stays on.
- R9: `rdy_sink_en` is 1 in the cycle after a cycle with `init_done` at 1, and 0 in the cycle after `init_done` at 0.
- R10: During reset `flash_wp_n` is 1, `prot_status`, `act_sink_en`, `rdy_sink_en` and `cfg_wr_grant` are 0, and the switch is taken as released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wp_switch_n | input | 1 | Raw write-protect switch, low requests protection |
| xfer_start | input | 1 | One-cycle strobe, data transfer begins |
| xfer_done | input | 1 | One-cycle strobe, data transfer ends |
| ops_pending | input | 1 | Controller core has internal flash work queued |
| init_done | input | 1 | Device powered and initialized |
| cfg_wr_req | input | 1 | Write request to the configuration data area |
| cfg_wr_grant | output | 1 | Configuration write allowed |
| cfg_wr_reject | output | 1 | Configuration write refused |
| prot_status | output | 1 | Media reported as write-protected to host logic |
| flash_wp_n | output | 1 | Flash write-protect line, low protects |
| act_sink_en | output | 1 | Activity indicator sinks (1) or is high-Z (0) |
| rdy_sink_en | output | 1 | Ready indicator sinks (1) or is high-Z (0) |

## Verification
Two events can land on the same clock edge: the deferred protection becoming free to apply, and a new transfer start strobe. The bench holds protection in its deferred state with `ops_pending`. It then drops `ops_pending` in exactly the cycle it raises `xfer_start`. The result is judged by `flash_wp_n` staying high through the new transfer and falling only the cycle after its finish strobe. A second case drives start and finish strobes together and expects the activity indicator to remain lit.

// File: rtl/wp_guard_pkg.sv
package wp_guard_pkg;
   typedef enum logic [1:0] {
      WP_OPEN   = 2'd0,
      WP_HOLD   = 2'd1,
      WP_LOCKED = 2'd2
   } wp_state_e;

   function automatic int unsigned cnt_width(input int unsigned n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/wp_sync_debounce.sv
module wp_sync_debounce #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned DEB_CYCLES  = 16,
   parameter bit          RESET_LEVEL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_i,
   output logic level_o
);
   import wp_guard_pkg::*;

   localparam int unsigned CNT_W = cnt_width(DEB_CYCLES);

   logic [SYNC_STAGES-1:0] chain_q;
   logic                   sync_lvl;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {SYNC_STAGES{RESET_LEVEL}};
      else        chain_q <= {chain_q[SYNC_STAGES-2:0], raw_i};
   end
   assign sync_lvl = chain_q[SYNC_STAGES-1];

   generate
      if (DEB_CYCLES <= 1) begin : g_bypass
         assign level_o = sync_lvl;
      end else begin : g_filter
         logic [CNT_W-1:0] cnt_q;
         logic             filt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q  <= '0;
               filt_q <= RESET_LEVEL;
            end else if (sync_lvl == filt_q) begin
               cnt_q <= '0;
            end else if (cnt_q == CNT_W'(DEB_CYCLES - 1)) begin
               cnt_q  <= '0;
               filt_q <= sync_lvl;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
         assign level_o = filt_q;
      end
   endgenerate
endmodule

// File: rtl/wp_defer_ctl.sv
module wp_defer_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic prot_req,
   input  logic busy,
   output logic wp_applied
);
   import wp_guard_pkg::*;

   wp_state_e st_q, st_d;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         WP_OPEN:   if (prot_req) st_d = busy ? WP_HOLD : WP_LOCKED;
         WP_HOLD:   if (!prot_req) st_d = WP_OPEN;
                    else if (!busy) st_d = WP_LOCKED;
         WP_LOCKED: if (!prot_req) st_d = WP_OPEN;
         default:   st_d = WP_OPEN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= WP_OPEN;
      else        st_q <= st_d;
   end

   assign wp_applied = (st_q == WP_LOCKED);
endmodule

// File: rtl/wp_led_drv.sv
module wp_led_drv #(
   parameter bit START_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic done_i,
   input  logic init_i,
   output logic act_o,
   output logic rdy_o
);
   logic act_q, act_d, rdy_q;

   generate
      if (START_WINS) begin : g_start_first
         always_comb begin
            act_d = act_q;
            if (done_i)  act_d = 1'b0;
            if (start_i) act_d = 1'b1;
         end
      end else begin : g_done_first
         always_comb begin
            act_d = act_q;
            if (start_i) act_d = 1'b1;
            if (done_i)  act_d = 1'b0;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q <= 1'b0;
         rdy_q <= 1'b0;
      end else begin
         act_q <= act_d;
         rdy_q <= init_i;
      end
   end

   assign act_o = act_q;
   assign rdy_o = rdy_q;
endmodule

// File: rtl/wp_guard.sv
module wp_guard #(
   parameter int unsigned SYNC_STAGES    = 2,
   parameter int unsigned DEB_CYCLES     = 16,
   parameter bit          ACT_START_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wp_switch_n,
   input  logic xfer_start,
   input  logic xfer_done,
   input  logic ops_pending,
   input  logic init_done,
   input  logic cfg_wr_req,
   output logic cfg_wr_grant,
   output logic cfg_wr_reject,
   output logic prot_status,
   output logic flash_wp_n,
   output logic act_sink_en,
   output logic rdy_sink_en
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("wp_guard: SYNC_STAGES must be at least 2");
      end
      if (DEB_CYCLES < 1) begin : g_bad_deb
         $error("wp_guard: DEB_CYCLES must be at least 1");
      end
   endgenerate

   logic sw_level;
   logic core_busy;
   logic wp_applied;

   wp_sync_debounce #(
      .SYNC_STAGES (SYNC_STAGES),
      .DEB_CYCLES  (DEB_CYCLES),
      .RESET_LEVEL (1'b1)
   ) u_filter (
      .clk     (clk),
      .rst_n   (rst_n),
      .raw_i   (wp_switch_n),
      .level_o (sw_level)
   );

   wp_led_drv #(
      .START_WINS (ACT_START_WINS)
   ) u_leds (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (xfer_start),
      .done_i  (xfer_done),
      .init_i  (init_done),
      .act_o   (act_sink_en),
      .rdy_o   (rdy_sink_en)
   );

   assign prot_status = ~sw_level;
   assign core_busy   = act_sink_en | xfer_start | ops_pending;

   wp_defer_ctl u_defer (
      .clk        (clk),
      .rst_n      (rst_n),
      .prot_req   (prot_status),
      .busy       (core_busy),
      .wp_applied (wp_applied)
   );

   assign flash_wp_n    = ~wp_applied;
   assign cfg_wr_grant  = cfg_wr_req & ~prot_status;
   assign cfg_wr_reject = cfg_wr_req &  prot_status;
endmodule

// File: rtl/wp_guard_chk.sv
module wp_guard_chk (
   input logic clk,
   input logic rst_n,
   input logic xfer_start,
   input logic ops_pending,
   input logic init_done,
   input logic cfg_wr_req,
   input logic cfg_wr_grant,
   input logic cfg_wr_reject,
   input logic prot_status,
   input logic flash_wp_n,
   input logic act_sink_en,
   input logic rdy_sink_en
);
   AST_WP_APPLY: assert property (@(posedge clk) disable iff (!rst_n)
      (prot_status && !act_sink_en && !xfer_start && !ops_pending) |=> !flash_wp_n); // R3

   AST_WP_DEFER: assert property (@(posedge clk) disable iff (!rst_n)
      (flash_wp_n && (act_sink_en || ops_pending)) |=> flash_wp_n); // R4

   AST_WP_START_DEFER: assert property (@(posedge clk) disable iff (!rst_n)
      (flash_wp_n && xfer_start) |=> flash_wp_n); // R5

   AST_WP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      !prot_status |=> flash_wp_n); // R6

   AST_CFG_ONE_HOT: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({cfg_wr_grant, cfg_wr_reject}) == {1'b0, cfg_wr_req}); // R7

   AST_CFG_PROT_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr_req && prot_status) |-> cfg_wr_reject); // R7

   AST_ACT_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_start |=> act_sink_en); // R8

   AST_RDY_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
      init_done |=> rdy_sink_en); // R9
endmodule

bind wp_guard wp_guard_chk chk_i (
   .clk           (clk),
   .rst_n         (rst_n),
   .xfer_start    (xfer_start),
   .ops_pending   (ops_pending),
   .init_done     (init_done),
   .cfg_wr_req    (cfg_wr_req),
   .cfg_wr_grant  (cfg_wr_grant),
   .cfg_wr_reject (cfg_wr_reject),
   .prot_status   (prot_status),
   .flash_wp_n    (flash_wp_n),
   .act_sink_en   (act_sink_en),
   .rdy_sink_en   (rdy_sink_en)
);

// File: tb/wp_guard_tb_top.sv
`timescale 1ns/1ps
module wp_guard_tb_top;
   localparam int unsigned DEB = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wp_switch_n = 1'b1;
   logic xfer_start = 1'b0, xfer_done = 1'b0, ops_pending = 1'b0;
   logic init_done = 1'b0, cfg_wr_req = 1'b0;
   logic cfg_wr_grant, cfg_wr_reject, prot_status, flash_wp_n, act_sink_en, rdy_sink_en;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   wp_guard #(.SYNC_STAGES(2), .DEB_CYCLES(DEB), .ACT_START_WINS(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .wp_switch_n(wp_switch_n),
      .xfer_start(xfer_start), .xfer_done(xfer_done), .ops_pending(ops_pending),
      .init_done(init_done), .cfg_wr_req(cfg_wr_req),
      .cfg_wr_grant(cfg_wr_grant), .cfg_wr_reject(cfg_wr_reject),
      .prot_status(prot_status), .flash_wp_n(flash_wp_n),
      .act_sink_en(act_sink_en), .rdy_sink_en(rdy_sink_en)
   );

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic expect_eq(input string tag, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %b expected %b", tag, act, exp);
      end
   endtask

   task automatic pulse_start();
      xfer_start = 1'b1; cyc(1); xfer_start = 1'b0;
   endtask

   task automatic pulse_done();
      xfer_done = 1'b1; cyc(1); xfer_done = 1'b0;
   endtask

   task automatic t_reset();
      cyc(2);
      expect_eq("R10 flash_wp_n", flash_wp_n, 1'b1);
      expect_eq("R10 prot_status", prot_status, 1'b0);
      expect_eq("R10 act_sink_en", act_sink_en, 1'b0);
      expect_eq("R10 rdy_sink_en", rdy_sink_en, 1'b0);
      expect_eq("R10 cfg_wr_grant", cfg_wr_grant, 1'b0);
      rst_n = 1'b1;
      cyc(2);
   endtask

   task automatic t_press_release_idle();
      wp_switch_n = 1'b0;
      cyc(DEB);
      expect_eq("R1 not before filter", prot_status, 1'b0);
      cyc(3);
      expect_eq("R1 protected", prot_status, 1'b1);
      expect_eq("R3 applied when idle", flash_wp_n, 1'b0);
      cfg_wr_req = 1'b1; #1;
      expect_eq("R7 reject when protected", cfg_wr_reject, 1'b1);
      expect_eq("R7 no grant when protected", cfg_wr_grant, 1'b0);
      cyc(1); cfg_wr_req = 1'b0;
      wp_switch_n = 1'b1;
      cyc(DEB + 2);
      expect_eq("R1 released", prot_status, 1'b0);
      expect_eq("R6 one cycle after release", flash_wp_n, 1'b0);
      cyc(1);
      expect_eq("R6 flash line lifted", flash_wp_n, 1'b1);
      cfg_wr_req = 1'b1; #1;
      expect_eq("R7 grant when open", cfg_wr_grant, 1'b1);
      expect_eq("R7 no reject when open", cfg_wr_reject, 1'b0);
      cyc(1); cfg_wr_req = 1'b0;
   endtask

   task automatic t_glitch();
      wp_switch_n = 1'b0;
      cyc(DEB - 3);
      wp_switch_n = 1'b1;
      cyc(DEB + 6);
      expect_eq("R2 glitch status", prot_status, 1'b0);
      expect_eq("R2 glitch flash line", flash_wp_n, 1'b1);
   endtask

   task automatic t_defer_transfer();
      pulse_start();
      expect_eq("R8 activity on", act_sink_en, 1'b1);
      wp_switch_n = 1'b0;
      cyc(DEB + 8);
      expect_eq("R1 status during transfer", prot_status, 1'b1);
      expect_eq("R4 deferred by transfer", flash_wp_n, 1'b1);
      cfg_wr_req = 1'b1; #1;
      expect_eq("R7 reject while deferred", cfg_wr_reject, 1'b1);
      cyc(1); cfg_wr_req = 1'b0;
      pulse_done();
      expect_eq("R8 activity off", act_sink_en, 1'b0);
      expect_eq("R4 not yet applied", flash_wp_n, 1'b1);
      cyc(1);
      expect_eq("R4 applied after transfer", flash_wp_n, 1'b0);
      wp_switch_n = 1'b1;
      cyc(DEB + 4);
      expect_eq("R6 lifted after release", flash_wp_n, 1'b1);
   endtask

   task automatic t_defer_ops();
      ops_pending = 1'b1;
      wp_switch_n = 1'b0;
      cyc(DEB + 8);
      expect_eq("R4 deferred by pending ops", flash_wp_n, 1'b1);
      ops_pending = 1'b0;
      cyc(1);
      expect_eq("R4 applied after ops drain", flash_wp_n, 1'b0);
      wp_switch_n = 1'b1;
      cyc(DEB + 4);
      expect_eq("R6 lifted", flash_wp_n, 1'b1);
   endtask

   task automatic t_coincide();
      ops_pending = 1'b1;
      wp_switch_n = 1'b0;
      cyc(DEB + 8);
      ops_pending = 1'b0;
      pulse_start();
      expect_eq("R5 start defers apply", flash_wp_n, 1'b1);
      cyc(5);
      expect_eq("R5 still deferred in transfer", flash_wp_n, 1'b1);
      pulse_done();
      cyc(1);
      expect_eq("R5 applied after new transfer", flash_wp_n, 1'b0);
      wp_switch_n = 1'b1;
      cyc(DEB + 4);
      expect_eq("R6 lifted", flash_wp_n, 1'b1);
   endtask

   task automatic t_activity_same_cycle();
      pulse_start();
      xfer_start = 1'b1; xfer_done = 1'b1;
      cyc(1);
      xfer_start = 1'b0; xfer_done = 1'b0;
      expect_eq("R8 start wins over done", act_sink_en, 1'b1);
      pulse_done();
      expect_eq("R8 off after done", act_sink_en, 1'b0);
   endtask

   task automatic t_ready();
      init_done = 1'b1;
      cyc(1);
      expect_eq("R9 ready on", rdy_sink_en, 1'b1);
      init_done = 1'b0;
      cyc(1);
      expect_eq("R9 ready off", rdy_sink_en, 1'b0);
      init_done = 1'b1;
      cyc(1);
   endtask

   initial begin
      t_reset();
      t_press_release_idle();
      t_glitch();
      t_defer_transfer();
      t_defer_ops();
      t_coincide();
      t_activity_same_cycle();
      t_ready();
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule